// File: doc/BRIEF.md
# Serial Mode Control Register

This block is the host-facing mode register of a disk-drive motor controller. A host microcontroller drives three pins: an active-low chip-select, a serial clock and a serial data line. The block brings all three into the system clock domain through synchroniser chains. It detects the pin edges there and shifts a 6-bit command word into a shadow register. The decoded mode outputs keep the previous word for the whole transfer.

The new word becomes active only when chip-select returns high, and only if the transfer is well formed. A well-formed transfer starts with the serial clock low and carries exactly six clock rising edges. On every accepted word the block raises a one-cycle commit strobe. It raises a separate one-cycle retract strobe when an accepted word takes the enable bit from 1 to 0, so that a power sequencer can start parking the heads. After reset the register holds all zeros, which selects sleep.

Top module: `mcr_serial_ctrl`

## Requirements
- R1: After reset all outputs are 0: mode_enable=0 (sleep), spin_brake=0, ilim_code=00, vcm_idle=0, step_mode=0, and both strobes are low.
- R2: The word is sent with bit 5 first and bit 0 last, one bit for each serial-clock rising edge while chip-select is low. Once committed, bit 0 drives mode_enable (1 = run, 0 = sleep), bit 1 drives spin_brake, bit 4 drives vcm_idle and bit 5 drives step_mode.
- R3: While a word is being shifted in, every mode output keeps its previous value. The mode outputs change only in the cycle in which commit_stb is high.
- R4: A chip-select rising edge that ends a well-formed transfer loads the shifted word and produces exactly one commit_stb pulse, one clock cycle long.
- R5: While chip-select is high, serial-clock and data activity changes no output and produces no strobe.
- R6: A transfer that ends with a number of clock edges other than 6 (for example 0, 5 or 7) is discarded. The outputs are unchanged and no strobe is produced.
- R7: A transfer whose chip-select falls while the serial clock is high is discarded, even if it carries six clock edges.
- R8: retract_stb pulses for one cycle, together with commit_stb, exactly when a committed word has bit 0 = 0 and the previous active word had bit 0 = 1.
- R9: ilim_code = {bit 2, bit 3} of the committed word. 00 selects the highest spindle current limit and 11 the lowest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_pin | input | 1 | Asynchronous active-low chip-select from host |
| sclk_pin | input | 1 | Asynchronous serial clock from host |
| sdata_pin | input | 1 | Asynchronous serial data from host |
| mode_enable | output | 1 | 1 = run, 0 = sleep |
| spin_brake | output | 1 | Spindle disabled and braked |
| ilim_code | output | 2 | Spindle current-limit level, 00 highest |
| vcm_idle | output | 1 | Actuator disabled and braked, spindle running |
| step_mode | output | 1 | Spindle single-step commutation mode |
| commit_stb | output | 1 | One-cycle pulse on each accepted word |
| retract_stb | output | 1 | One-cycle pulse when enable goes from 1 to 0 |

## Verification
The hardest cases to reach are the transfers that must be rejected. One is a transfer that starts with the serial clock already high. Others are transfers that carry five or seven edges. Rejecting them must leave the register untouched, and the register must not be cleared as a side effect. The bench first loads a known nonzero word and then drives each malformed transfer at pin level, with the same timing it uses for legal writes. It also stops one transfer after the sixth edge but before chip-select rises, to confirm that the old word is still held. The full sweep over all 64 words goes in rising order, so D0 alternates and every 1-to-0 retract case is covered.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  localparam int WORD_W   = 6;
  localparam int BIT_EN   = 0;
  localparam int BIT_BRK  = 1;
  localparam int BIT_IL_H = 2;
  localparam int BIT_IL_L = 3;
  localparam int BIT_IDLE = 4;
  localparam int BIT_STEP = 5;
endpackage

// File: rtl/mcr_sync.sv
module mcr_sync #(
  parameter int N_PINS = 3,
  parameter int STAGES = 2,
  parameter logic [N_PINS-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] d_async,
  output logic [N_PINS-1:0] q_sync
);
  genvar p;
  generate
    for (p = 0; p < N_PINS; p++) begin : g_pin
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL[p]}};
        else     chain <= {chain[STAGES-2:0], d_async[p]};
      end
      assign q_sync[p] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/mcr_shifter.sv
module mcr_shifter #(
  parameter int WORD_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              sdata_s,
  output logic              commit_req,
  output logic [WORD_W-1:0] word
);
  localparam int CNT_MAX = WORD_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic              cs_n_q, sclk_q;
  logic              start_ok;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] shreg;
  logic              cs_fall, cs_rise, clk_rise;

  assign cs_fall  = cs_n_q & ~cs_n_s;
  assign cs_rise  = ~cs_n_q & cs_n_s;
  assign clk_rise = ~sclk_q & sclk_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n_q   <= 1'b1;
      sclk_q   <= 1'b0;
      start_ok <= 1'b0;
      cnt      <= '0;
      shreg    <= '0;
    end else begin
      cs_n_q <= cs_n_s;
      sclk_q <= sclk_s;
      if (cs_n_s) begin
        cnt <= '0;
      end else if (cs_fall) begin
        start_ok <= ~sclk_s;
        cnt      <= '0;
      end else if (clk_rise) begin
        shreg <= {shreg[WORD_W-2:0], sdata_s};
        if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
      end
    end
  end

  assign commit_req = cs_rise & start_ok & (cnt == CNT_W'(WORD_W));
  assign word       = shreg;
endmodule

// File: rtl/mcr_mode_reg.sv
module mcr_mode_reg #(
  parameter int WORD_W = 6,
  parameter int EN_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_req,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] active,
  output logic              commit_stb,
  output logic              retract_stb
);
  always_ff @(posedge clk) begin
    if (rst) begin
      active      <= '0;
      commit_stb  <= 1'b0;
      retract_stb <= 1'b0;
    end else begin
      commit_stb  <= commit_req;
      retract_stb <= commit_req & active[EN_BIT] & ~word[EN_BIT];
      if (commit_req) active <= word;
    end
  end
endmodule

// File: rtl/mcr_serial_ctrl.sv
module mcr_serial_ctrl
  import mcr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n_pin,
  input  logic       sclk_pin,
  input  logic       sdata_pin,
  output logic       mode_enable,
  output logic       spin_brake,
  output logic [1:0] ilim_code,
  output logic       vcm_idle,
  output logic       step_mode,
  output logic       commit_stb,
  output logic       retract_stb
);
  logic [2:0]        pins_s;
  logic              commit_req;
  logic [WORD_W-1:0] word, active;

  mcr_sync #(.N_PINS(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst(rst),
    .d_async({sdata_pin, sclk_pin, cs_n_pin}),
    .q_sync(pins_s)
  );

  mcr_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst),
    .cs_n_s(pins_s[0]), .sclk_s(pins_s[1]), .sdata_s(pins_s[2]),
    .commit_req(commit_req), .word(word)
  );

  mcr_mode_reg #(.WORD_W(WORD_W), .EN_BIT(BIT_EN)) u_reg (
    .clk(clk), .rst(rst),
    .commit_req(commit_req), .word(word),
    .active(active), .commit_stb(commit_stb), .retract_stb(retract_stb)
  );

  assign mode_enable = active[BIT_EN];
  assign spin_brake  = active[BIT_BRK];
  assign ilim_code   = {active[BIT_IL_H], active[BIT_IL_L]};
  assign vcm_idle    = active[BIT_IDLE];
  assign step_mode   = active[BIT_STEP];
endmodule

// File: rtl/mcr_checker.sv
module mcr_checker (
  input logic       clk,
  input logic       rst,
  input logic       mode_enable,
  input logic       spin_brake,
  input logic [1:0] ilim_code,
  input logic       vcm_idle,
  input logic       step_mode,
  input logic       commit_stb,
  input logic       retract_stb
);
  logic [5:0] outs;
  assign outs = {step_mode, vcm_idle, ilim_code, spin_brake, mode_enable};

  AST_RESET_SLEEP: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (outs == 6'd0 && !commit_stb && !retract_stb)); // R1

  AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !commit_stb |-> $stable(outs)); // R3

  AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    commit_stb |=> !commit_stb); // R4

  AST_RETRACT_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    retract_stb |-> (commit_stb && !mode_enable && $past(mode_enable))); // R8

  AST_RETRACT_ON_EVERY_FALL: assert property (@(posedge clk) disable iff (rst)
    (commit_stb && !mode_enable && $past(mode_enable)) |-> retract_stb); // R8
endmodule

bind mcr_serial_ctrl mcr_checker u_chk (
  .clk(clk), .rst(rst),
  .mode_enable(mode_enable), .spin_brake(spin_brake), .ilim_code(ilim_code),
  .vcm_idle(vcm_idle), .step_mode(step_mode),
  .commit_stb(commit_stb), .retract_stb(retract_stb)
);

// File: tb/mcr_serial_ctrl_tb.sv
`timescale 1ns/1ps
module mcr_serial_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n_pin = 1'b1, sclk_pin = 1'b0, sdata_pin = 1'b0;
  logic mode_enable, spin_brake, vcm_idle, step_mode, commit_stb, retract_stb;
  logic [1:0] ilim_code;
  int checks = 0, failures = 0, n_commit = 0, n_retract = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mcr_serial_ctrl u_dut (
    .clk(clk), .rst(rst), .cs_n_pin(cs_n_pin), .sclk_pin(sclk_pin),
    .sdata_pin(sdata_pin), .mode_enable(mode_enable), .spin_brake(spin_brake),
    .ilim_code(ilim_code), .vcm_idle(vcm_idle), .step_mode(step_mode),
    .commit_stb(commit_stb), .retract_stb(retract_stb)
  );

  always @(negedge clk) begin
    if (!rst && commit_stb)  n_commit++;
    if (!rst && retract_stb) n_retract++;
  end

  function automatic logic [5:0] outs();
    return {step_mode, vcm_idle, ilim_code, spin_brake, mode_enable};
  endfunction

  function automatic logic [5:0] expect_outs(input logic [5:0] w);
    return {w[5], w[4], w[2], w[3], w[1], w[0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdata_pin = v[i];
      wait_n(4);
      sclk_pin = 1'b1;
      wait_n(6);
      sclk_pin = 1'b0;
      wait_n(4);
    end
  endtask

  task automatic write_bits(input logic [15:0] v, input int n, input bit bad_start);
    if (bad_start) begin sclk_pin = 1'b1; wait_n(6); end
    cs_n_pin = 1'b0;
    wait_n(6);
    if (bad_start) begin sclk_pin = 1'b0; wait_n(6); end
    shift_bits(v, n);
    cs_n_pin = 1'b1;
    wait_n(10);
  endtask

  initial begin
    #700000;
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [5:0] prev;
    int c0, r0;
    wait_n(5);
    rst = 1'b0;
    wait_n(3);
    check("R1 reset outputs", {26'd0, outs()}, 32'd0);
    check("R1 reset strobes", {30'd0, commit_stb, retract_stb}, 32'd0);

    prev = 6'd0;
    for (int w = 0; w < 64; w++) begin
      c0 = n_commit; r0 = n_retract;
      write_bits(16'(w), 6, 1'b0);
      check("R2 decoded word", {26'd0, outs()}, {26'd0, expect_outs(6'(w))});
      check("R9 ilim code", {30'd0, ilim_code}, {30'd0, w[2], w[3]});
      check("R4 one commit", n_commit - c0, 1);
      check("R8 retract", n_retract - r0, (prev[0] && !w[0]) ? 1 : 0);
      prev = 6'(w);
    end

    write_bits(16'h2B, 6, 1'b0);
    prev = 6'h2B;

    c0 = n_commit;
    write_bits(16'h15, 5, 1'b0);
    check("R6 five bits held", {26'd0, outs()}, {26'd0, expect_outs(prev)});
    write_bits(16'h55, 7, 1'b0);
    check("R6 seven bits held", {26'd0, outs()}, {26'd0, expect_outs(prev)});
    write_bits(16'h0, 0, 1'b0);
    check("R6 zero bits held", {26'd0, outs()}, {26'd0, expect_outs(prev)});
    check("R6 no commit", n_commit - c0, 0);

    c0 = n_commit;
    write_bits(16'h14, 6, 1'b1);
    check("R7 bad start held", {26'd0, outs()}, {26'd0, expect_outs(prev)});
    check("R7 no commit", n_commit - c0, 0);

    c0 = n_commit;
    for (int k = 0; k < 8; k++) begin
      sdata_pin = k[0];
      wait_n(3); sclk_pin = 1'b1; wait_n(5); sclk_pin = 1'b0; wait_n(3);
    end
    wait_n(10);
    check("R5 cs high held", {26'd0, outs()}, {26'd0, expect_outs(prev)});
    check("R5 no commit", n_commit - c0, 0);

    c0 = n_commit; r0 = n_retract;
    cs_n_pin = 1'b0;
    wait_n(6);
    shift_bits(16'h14, 6);
    wait_n(10);
    check("R3 held before cs rise", {26'd0, outs()}, {26'd0, expect_outs(prev)});
    check("R3 no early commit", n_commit - c0, 0);
    cs_n_pin = 1'b1;
    wait_n(10);
    check("R3 new word after cs rise", {26'd0, outs()}, {26'd0, expect_outs(6'h14)});
    check("R8 retract on 1 to 0", n_retract - r0, 1);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule